// File: doc/BRIEF.md
# Multicast Hash Address Filter

The filter decides whether a received frame with a group destination address should be kept. It watches the first six bytes of each frame, which form the destination address. They arrive one byte per cycle with a valid strobe, and a start-of-frame strobe marks the first byte. The block runs a 32-bit Ethernet CRC over those bytes and reduces the result to a 6-bit hash. That hash picks one bit of a 64-bit filter table. If the frame is multicast and the picked bit is set, the frame is accepted.

The host programs the filter table as eight byte-wide registers and can read them back. A pass-all-multicast input accepts every group frame whatever the table holds. The hash is output with every result, unicast frames included. Receive software stores it in the frame status and uses it to limit its exact-address search to the addresses that share that hash.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, all eight table registers read 0, and `res_valid_o` and `mcast_accept_o` are 0.
- R2: A write with `reg_we_i` high stores `reg_wdata_i` into table register `reg_addr_i` (0 to 7) at the clock edge. From the next cycle, `reg_rdata_o` returns the stored byte of the register that `reg_addr_i` selects.
- R3: The CRC uses polynomial 0x04C11DB7, starts from all ones at each start-of-frame byte, and takes each byte least significant bit first. Seen as a left-shifting register, `hash_o[5:0]` is register bits 31 down to 26 after the sixth byte, with no final inversion.
- R4: The lookup bit is bit `hash[2:0]` of table register `hash[5:3]`.
- R5: A multicast frame (bit 0 of the first byte is 1) is accepted when its lookup bit is 1 and rejected when it is 0.
- R6: While `pass_all_i` is 1, every multicast frame is accepted whatever the table holds.
- R7: A frame with bit 0 of its first byte at 0 gives `mcast_accept_o` = 0 even if its lookup bit is set or `pass_all_i` is 1. Its hash is still reported with a valid pulse.
- R8: `res_valid_o` is a one-cycle pulse in the cycle after the sixth valid byte is taken. Cycles with `byte_valid_i` low are not counted. Bytes after the sixth are ignored until the next start-of-frame, and `hash_o` holds its value meanwhile.
- R9: A table write whose clock edge is at or before the edge that takes the sixth byte affects that frame's decision. A write issued in the result cycle does not affect it.
- R10: A start-of-frame byte in the middle of an address restarts the CRC and the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Marks the current byte as the first byte of a frame |
| byte_valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Received byte |
| pass_all_i | input | 1 | Accept all multicast frames |
| reg_we_i | input | 1 | Table register write enable |
| reg_addr_i | input | 3 | Table register select |
| reg_wdata_i | input | 8 | Table register write data |
| reg_rdata_o | output | 8 | Selected table register contents |
| res_valid_o | output | 1 | One-cycle result pulse |
| mcast_accept_o | output | 1 | Multicast accept decision |
| hash_o | output | 6 | Hash of the last destination address |

## Verification
A host write to the table and the lookup of a frame can fall in the same cycle. The bench provokes both orders. In one, a write that sets the frame's lookup bit is issued together with the sixth byte, and the frame must be accepted. In the other, the write is issued in the result cycle itself, and the decision must stay at reject. A later read then confirms that the write still landed.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  parameter int unsigned CRC_W = 32;
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  parameter logic [CRC_W-1:0] CRC_INIT = '1;

  // one byte, lsb first, msb-first register form
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter int unsigned NBYTES = 6,
  parameter int unsigned HASH_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  output logic              done_o,
  output logic              mcast_o,
  output logic [HASH_W-1:0] hash_o
);
  localparam int unsigned CNT_W = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBYTES);

  logic [CRC_W-1:0] crc_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             active_q, done_q, mcast_q, consume;

  assign consume = valid_i && (sof_i || active_q);
  assign cnt_nxt = sof_i ? CNT_W'(1) : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q    <= CRC_INIT;
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      mcast_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (consume) begin
        crc_q    <= crc_byte(sof_i ? CRC_INIT : crc_q, data_i);
        cnt_q    <= cnt_nxt;
        active_q <= (cnt_nxt != CNT_LAST);
        done_q   <= (cnt_nxt == CNT_LAST);
        if (sof_i) mcast_q <= data_i[0];
      end
    end
  end

  assign done_o  = done_q;
  assign mcast_o = mcast_q;
  assign hash_o  = crc_q[CRC_W-1 -: HASH_W];

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(consume) && ($past(cnt_nxt) == CNT_LAST)); // R8
  AST_HASH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !consume |=> $stable(crc_q)); // R8
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned REG_W = 8,
  localparam int unsigned SEL_W = $clog2(NREGS),
  localparam int unsigned BIT_W = $clog2(REG_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [SEL_W-1:0]       addr_i,
  input  logic [REG_W-1:0]       wdata_i,
  output logic [REG_W-1:0]       rdata_o,
  input  logic [SEL_W+BIT_W-1:0] idx_i,
  output logic                   bit_o
);
  logic [REG_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && addr_i == SEL_W'(g))         regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[addr_i];
  // upper index bits select the register, lower bits the bit
  assign bit_o   = regs_q[idx_i[SEL_W+BIT_W-1 -: SEL_W]][idx_i[BIT_W-1:0]];

  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (addr_i != $past(addr_i)) || (rdata_o == $past(wdata_i))); // R2
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int unsigned NREGS  = 8,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned NBYTES = 6,
  localparam int unsigned SEL_W  = $clog2(NREGS),
  localparam int unsigned HASH_W = $clog2(NREGS) + $clog2(REG_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              pass_all_i,
  input  logic              reg_we_i,
  input  logic [SEL_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              res_valid_o,
  output logic              mcast_accept_o,
  output logic [HASH_W-1:0] hash_o
);
  logic              done, mcast, tbl_bit;
  logic [HASH_W-1:0] hash;

  mhf_crc_engine #(.NBYTES(NBYTES), .HASH_W(HASH_W)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (sof_i),
    .valid_i(byte_valid_i),
    .data_i (byte_i),
    .done_o (done),
    .mcast_o(mcast),
    .hash_o (hash)
  );

  // lookup reads the table state present in the result cycle
  mhf_table #(.NREGS(NREGS), .REG_W(REG_W)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .idx_i  (hash),
    .bit_o  (tbl_bit)
  );

  assign res_valid_o    = done;
  assign hash_o         = hash;
  assign mcast_accept_o = done && mcast && (pass_all_i || tbl_bit);

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R8
  AST_HASH_STABLE_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !byte_valid_i |=> $stable(hash_o)); // R8
endmodule

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, bval = 1'b0, pass_all = 1'b0, we = 1'b0;
  logic [7:0] bdat = '0, wdata = '0, rdata;
  logic [2:0] addr = '0;
  logic       rvalid, acc;
  logic [5:0] hash;

  int n_chk = 0, n_bad = 0;
  logic [7:0] shadow [8];

  always #10 clk = ~clk;

  mcast_hash_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_valid_i(bval), .byte_i(bdat),
    .pass_all_i(pass_all), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .res_valid_o(rvalid), .mcast_accept_o(acc), .hash_o(hash)
  );

  localparam logic [47:0] FR_A = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] FR_B = 48'h33_33_00_00_00_01;
  localparam logic [47:0] FR_C = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] FR_U = 48'h00_11_22_33_44_55;

  // reflected form: right shift with reversed polynomial
  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = a[47-8*k -: 8];
      for (int i = 0; i < 8; i++) begin
        logic l = r[0] ^ b[i];
        r = r >> 1;
        if (l) r = r ^ 32'hEDB8_8320;
      end
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic logic exp_acc(input logic [47:0] a, input logic pa);
    logic [5:0] h = ref_hash(a);
    return a[40] && (pa || shadow[h[5:3]][h[2:0]]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bval = 1'b0; sof = 1'b0; we = 1'b0;
    #1;
  endtask

  task automatic drive_byte(input logic [7:0] b, input logic s);
    @(negedge clk);
    bval = 1'b1; bdat = b; sof = s; we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; bval = 1'b0; sof = 1'b0;
    shadow[a] = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < 8; i++) wr(3'(i), 8'h00);
  endtask

  task automatic drive_frame(input logic [47:0] a);
    for (int k = 0; k < 6; k++) drive_byte(a[47-8*k -: 8], k == 0);
  endtask

  // at the result cycle, then one cycle later
  task automatic check_result(input string tag, input logic [47:0] a);
    chk({tag, " valid"}, 32'(rvalid), 32'd1);
    chk({tag, " hash"}, 32'(hash), 32'(ref_hash(a)));
    chk({tag, " accept"}, 32'(acc), 32'(exp_acc(a, pass_all)));
    idle();
    chk({tag, " pulse end"}, 32'(rvalid), 32'd0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); addr = 3'(i); #1;
      chk("R1 reg reset", 32'(rdata), 32'd0);
    end
    chk("R1 valid reset", 32'(rvalid), 32'd0);
    chk("R1 accept reset", 32'(acc), 32'd0);
  endtask

  task automatic t_regs();
    for (int i = 0; i < 8; i++) wr(3'(i), 8'(8'h5A ^ (i * 37)));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); addr = 3'(i); #1;
      chk("R2 readback", 32'(rdata), 32'(shadow[i]));
    end
    clear_tbl();
  endtask

  task automatic t_lookup();
    logic [5:0] h = ref_hash(FR_A);
    drive_frame(FR_A); idle(); check_result("R3 R5 reject A", FR_A);
    drive_frame(FR_B); idle(); check_result("R3 reject B", FR_B);
    drive_frame(FR_C); idle(); check_result("R3 reject C", FR_C);
    wr(h[5:3], 8'(1 << h[2:0]));
    drive_frame(FR_A); idle(); check_result("R4 R5 accept A", FR_A);
    chk("R5 accept A", 32'(exp_acc(FR_A, 1'b0)), 32'd1);
    wr(h[5:3], ~8'(1 << h[2:0]));
    drive_frame(FR_A); idle(); check_result("R4 other bits A", FR_A);
    clear_tbl();
  endtask

  task automatic t_pass_all();
    pass_all = 1'b1;
    drive_frame(FR_B); idle(); check_result("R6 pass all B", FR_B);
    chk("R6 accepted", 32'(exp_acc(FR_B, 1'b1)), 32'd1);
    drive_frame(FR_U); idle(); check_result("R7 unicast pass all", FR_U);
    pass_all = 1'b0;
  endtask

  task automatic t_unicast();
    logic [5:0] h = ref_hash(FR_U);
    wr(h[5:3], 8'(1 << h[2:0]));
    drive_frame(FR_U); idle(); check_result("R7 unicast bit set", FR_U);
    chk("R7 accept 0", 32'(acc), 32'd0);
    clear_tbl();
  endtask

  task automatic t_gaps_extra();
    logic [5:0] h = ref_hash(FR_B);
    for (int k = 0; k < 6; k++) begin
      drive_byte(FR_B[47-8*k -: 8], k == 0);
      idle();
      if (k == 5) check_result("R8 gaps", FR_B);
      else chk("R8 no early valid", 32'(rvalid), 32'd0);
    end
    drive_frame(FR_C);
    drive_byte(8'hAA, 1'b0); #1;
    chk("R8 valid with extra", 32'(rvalid), 32'd1);
    chk("R8 hash with extra", 32'(hash), 32'(ref_hash(FR_C)));
    for (int k = 0; k < 3; k++) begin
      drive_byte(8'(8'h11 * k), 1'b0); #1;
      chk("R8 extra ignored valid", 32'(rvalid), 32'd0);
      chk("R8 extra ignored hash", 32'(hash), 32'(ref_hash(FR_C)));
    end
    idle(); idle();
    chk("R8 hash held", 32'(hash), 32'(ref_hash(FR_C)));
    if (h == ref_hash(FR_C)) chk("R8 distinct hashes", 32'd0, 32'd1);
  endtask

  task automatic t_restart();
    for (int k = 0; k < 3; k++) drive_byte(FR_B[47-8*k -: 8], k == 0);
    drive_frame(FR_A); idle(); check_result("R10 restart", FR_A);
  endtask

  task automatic t_race();
    logic [5:0] h = ref_hash(FR_A);
    for (int k = 0; k < 5; k++) drive_byte(FR_A[47-8*k -: 8], k == 0);
    drive_byte(FR_A[7:0], 1'b0);
    we = 1'b1; addr = h[5:3]; wdata = 8'(1 << h[2:0]);
    shadow[h[5:3]] = wdata;
    idle();
    chk("R9 early write accepted", 32'(acc), 32'd1);
    chk("R9 early write valid", 32'(rvalid), 32'd1);
    clear_tbl();
    drive_frame(FR_A);
    @(negedge clk);
    bval = 1'b0; sof = 1'b0;
    we = 1'b1; addr = h[5:3]; wdata = 8'(1 << h[2:0]);
    #1;
    chk("R9 late write valid", 32'(rvalid), 32'd1);
    chk("R9 late write no effect", 32'(acc), 32'd0);
    idle();
    chk("R9 late write landed", 32'(rdata), 32'(1 << h[2:0]));
    shadow[h[5:3]] = 8'(1 << h[2:0]);
    clear_tbl();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_regs();
    t_lookup();
    t_pass_all();
    t_unicast();
    t_gaps_extra();
    t_restart();
    t_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule